// File: doc/BRIEF.md
# Accumulator Store Postscale Shifter

This block sits between a 32-bit accumulator and the data-memory write path. When a store is requested, it takes either the upper or the lower 16-bit half of the accumulator, shifts that half left by 0 to 7 places, and presents the result as a registered 16-bit word together with a one-cycle valid pulse. The accumulator value is only read. A store never changes it.

The two halves fill the vacated bits in different ways. A shifted upper half is a 16-bit window of the full 32-bit value. Bits that move past bit 31 are discarded, and the bottom of the word is filled from the most significant bits of the lower half. A shifted lower half is filled with zeros from the bottom. This lets software write out a scaled fixed-point result without spending a separate accumulator shift.

Top module: `acc_store_shift`

## Requirements
- R1: The cycle after a clock edge that samples `store_stb` high, `word_valid` is 1 and `word_out` holds the shifted word for the inputs sampled at that edge.
- R2: The cycle after an edge that samples `store_stb` low, `word_valid` is 0 and `word_out` keeps its previous value. Changes on `acc_in`, `sel_high` or `shift_amt` without a strobe have no effect on `word_out`.
- R3: With `sel_high` = 1 and shift count n, `word_out` equals accumulator bits 31−n down to 16−n. Upper bits shifted past bit 31 are lost. Bit k of the result, for k below n, is accumulator bit 16−n+k, which comes from the top of the low half.
- R4: With `sel_high` = 0 and shift count n, `word_out` equals accumulator bits 15 to 0 shifted left by n and truncated to 16 bits. The n lowest bits are 0.
- R5: With a shift count of 0, `word_out` is exactly the selected half: bits 31 to 16 when `sel_high` = 1, and bits 15 to 0 when `sel_high` = 0.
- R6: While `rst_n` is low, and in the first cycle after it is released, `word_valid` is 0 and `word_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_in | input | 32 | Current accumulator value (read only) |
| sel_high | input | 1 | 1 selects bits 31..16, 0 selects bits 15..0 |
| shift_amt | input | 3 | Left shift count, 0 to 7 |
| store_stb | input | 1 | Store request for this cycle |
| word_out | output | 16 | Shifted half word for memory |
| word_valid | output | 1 | One-cycle pulse, word_out is new |

## Verification
Every shift count is run on both halves with accumulator patterns chosen so that a fill error shows up as a wrong bit. A lone one at the top of the low half shows whether the upper half takes its low bits from there or from zeros. An all-ones low half under a low-half store shows whether zeros are filled in. Alternating and single-bit patterns expose an off-by-one shift count. Strobe-free cycles with changing inputs show that the output word holds and the valid pulse lasts one cycle. Random stores with random gaps mix all of these.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;
    localparam int ACC_W   = 32;
    localparam int HALF_W  = ACC_W / 2;
    localparam int SHIFT_W = 3;

    typedef struct packed {
        logic              valid;
        logic [HALF_W-1:0] word;
    } store_out_t;
endpackage

// File: rtl/store_window.sv
module store_window #(
    parameter int ACC_W   = 32,
    parameter int SHIFT_W = 3
) (
    input  logic [ACC_W-1:0]   acc,
    input  logic               hi_sel,
    input  logic [SHIFT_W-1:0] amt,
    output logic [ACC_W/2-1:0] shifted
);
    localparam int HW    = ACC_W / 2;
    localparam int NSHFT = 1 << SHIFT_W;

    logic [HW-1:0] hi_cand [NSHFT];
    logic [HW-1:0] lo_cand [NSHFT];
    logic [HW-1:0] lo_half;

    assign lo_half = acc[HW-1:0];

    // Each candidate is one fixed shift. The upper half is a window
    // that slides down into the lower half.
    for (genvar k = 0; k < NSHFT; k++) begin : g_cand
        assign hi_cand[k] = acc[ACC_W-1-k -: HW];
        assign lo_cand[k] = lo_half << k;
    end

    always_comb begin
        if (hi_sel) shifted = hi_cand[amt];
        else        shifted = lo_cand[amt];
    end

    initial begin
        a_shift_fits: assert (NSHFT <= HW)
            else $error("shift range exceeds half width");
    end
endmodule

// File: rtl/store_stage.sv
module store_stage
    import acc_store_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [HALF_W-1:0] word_in,
    output store_out_t        out_q
);
    store_out_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.valid = stb;
        if (stb) state_d.word = word_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_q = state_q;

    p_pulse_after_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> state_q.valid);
    p_no_pulse_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> !state_q.valid);
    p_word_holds_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(state_q.word));
endmodule

// File: rtl/acc_store_shift.sv
module acc_store_shift
    import acc_store_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   acc_in,
    input  logic               sel_high,
    input  logic [SHIFT_W-1:0] shift_amt,
    input  logic               store_stb,
    output logic [HALF_W-1:0]  word_out,
    output logic               word_valid
);
    logic [HALF_W-1:0] shifted_w;
    store_out_t        stage_q;

    store_window #(.ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_window (
        .acc     (acc_in),
        .hi_sel  (sel_high),
        .amt     (shift_amt),
        .shifted (shifted_w)
    );

    store_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (store_stb),
        .word_in (shifted_w),
        .out_q   (stage_q)
    );

    assign word_out   = stage_q.word;
    assign word_valid = stage_q.valid;

    p_unshifted_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (store_stb && shift_amt == '0) |=>
            word_out == (($past(sel_high)) ? $past(acc_in[ACC_W-1:HALF_W])
                                           : $past(acc_in[HALF_W-1:0])));
    p_low_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_stb && !sel_high && shift_amt != '0) |=> !word_out[0]);
    p_high_fill_from_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (store_stb && sel_high && shift_amt != '0) |=>
            word_out[0] == $past(acc_in[HALF_W - 32'(shift_amt)]));
endmodule

// File: tb/acc_store_shift_test.sv
`timescale 1ns/1ps
module acc_store_shift_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] acc_in = '0;
    logic        sel_high = 1'b0;
    logic [2:0]  shift_amt = '0;
    logic        store_stb = 1'b0;
    logic [15:0] word_out;
    logic        word_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    acc_store_shift uut (
        .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .sel_high(sel_high),
        .shift_amt(shift_amt), .store_stb(store_stb),
        .word_out(word_out), .word_valid(word_valid)
    );

    // reference model, updated at each rising edge
    logic [15:0] exp_word  = '0;
    logic        exp_valid = 1'b0;
    string       exp_tag   = "R6";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_word = '0; exp_valid = 1'b0; exp_tag = "R6";
        end else begin
            exp_valid = store_stb;
            if (store_stb) begin
                logic [63:0] w;
                int n;
                n = int'(shift_amt);
                if (sel_high) begin
                    w = 64'(acc_in) << n;
                    exp_word = w[31:16];
                end else begin
                    w = 64'(acc_in[15:0]) << n;
                    exp_word = w[15:0];
                end
                if (n == 0) exp_tag = "R5";
                else exp_tag = sel_high ? "R3" : "R4";
            end else begin
                exp_tag = "R2";
            end
        end
    end

    task automatic check_now();
        n_checks++;
        if (word_valid !== exp_valid) begin
            n_fail++;
            $display("FAIL %s/R1 valid: actual %0b expected %0b", exp_tag, word_valid, exp_valid);
        end
        n_checks++;
        if (word_out !== exp_word) begin
            n_fail++;
            $display("FAIL %s data: actual %h expected %h", exp_tag, word_out, exp_word);
        end
    endtask

    task automatic step(input logic s, input logic hi, input logic [2:0] n, input logic [31:0] a);
        @(negedge clk);
        check_now();
        store_stb = s; sel_high = hi; shift_amt = n; acc_in = a;
    endtask

    logic [31:0] pats [6] = '{32'h0000_8000, 32'hFFFF_0000, 32'h0000_FFFF,
                              32'hA5A5_5A5A, 32'h8001_C003, 32'h1234_5678};

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        check_now();
        rst_n = 1'b1;
        @(negedge clk);
        check_now();
        // R3 R4 R5: all shifts on both halves
        foreach (pats[p]) begin
            for (int n = 0; n < 8; n++) begin
                step(1'b1, 1'b1, 3'(n), pats[p]);
                step(1'b1, 1'b0, 3'(n), pats[p]);
            end
        end
        // R2: idle cycles with moving inputs
        step(1'b1, 1'b1, 3'd3, 32'hDEAD_BEEF);
        for (int i = 0; i < 6; i++) step(1'b0, i[0], 3'(i), 32'h1111_1111 * i);
        // mixed random
        for (int i = 0; i < 2000; i++)
            step(($urandom % 3) != 0, 1'($urandom), 3'($urandom), $urandom);
        step(1'b0, 1'b0, 3'd0, 32'h0);
        step(1'b0, 1'b0, 3'd0, 32'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule